// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block pushes a configuration bitstream into a target programmable device over a two-wire serial configuration link (clock and data), with an active-low configuration-reset line and two status inputs from the target. A host pulses `start` with the total number of bytes on `byte_count` and then streams bytes over a valid/ready interface. The loader pulses configuration-reset, confirms the target acknowledges it on the active-low status line, waits for the target to release that line within a timeout, and then serialises every byte, least-significant bit first, one bit per configuration clock.

When the last bit has gone out, the loader requires the target's configuration-done input to be high. It then sends twelve trailing clock pulses and reports success. Any failed check, a release timeout or an `abort` request ends the load with `fail` set and all link outputs back to their quiet levels. The configuration clock half-period comes from a divider computed from the system clock frequency and a maximum link clock rate. All microsecond and millisecond waits come from counters derived from the same frequency parameter.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `cfg_rst_n` is 1, `cfg_clk` and `cfg_dat` are 0, and `busy`, `ok`, `fail` and `in_ready` are all 0.
- R2: On `start`, `cfg_rst_n` goes low for RST_US microseconds (500 system cycles at the defaults, at most 5 more). No `cfg_clk` rising edge occurs while it is low.
- R3: If the synchronised `cfg_status_n` is not low when the reset hold ends, the load fails. `cfg_rst_n` returns to 1 and no clock edge is ever issued.
- R4: After `cfg_rst_n` is released, the loader waits SETTLE_US. It then fails if `cfg_status_n` has not gone high within TIMEOUT_US. That gives a failure 500 + TIMEOUT cycles after the release, within 5 cycles.
- R5: Each byte is sent as 8 bits, bit 0 first. `cfg_dat` changes only while `cfg_clk` is low and is stable on every rising edge of `cfg_clk`, where the target samples it.
- R6: Every high and every low phase of `cfg_clk` lasts at least ceil(CLK_HZ / (2*CCLK_MAX_HZ)) system cycles, and never less than 3 (3 at the defaults, so the link clock runs at 50 MHz or below).
- R7: `in_ready` is high only when all 8 bits of the previous byte have been sent. Exactly `byte_count` bytes are accepted. While no byte is offered, `cfg_clk` stays low.
- R8: If `cfg_done` is not high after the last bit, the load fails and no trailing clocks are sent.
- R9: After `cfg_done` is confirmed, exactly 12 full clock pulses (high then low) are sent, then `ok` is set.
- R10: `abort` while `busy` sets `fail` and clears `busy` on the next clock edge. `cfg_rst_n` goes to 1 and `cfg_clk` and `cfg_dat` go to 0.
- R11: `ok` and `fail` are never both high. Each holds its value until the next `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| byte_count | input | LEN_W | Number of bytes in the load, sampled at start |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Loader accepts a byte this cycle |
| abort | input | 1 | Abandon the current load |
| cfg_rst_n | output | 1 | Active-low configuration reset to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_dat | output | 1 | Serial configuration data |
| cfg_status_n | input | 1 | Active-low target status |
| cfg_done | input | 1 | Target configuration complete |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| fail | output | 1 | Last load failed |

## Verification
A wrong bit counter or shift register shows up at the target model as a corrupted or misordered byte, or as a changed count of rising edges before `cfg_done`. It becomes visible no later than the end of the affected byte. A wrong timer load value appears as a reset pulse, release timeout or clock phase of the wrong length, which is measured in system cycles at the pins. A wrong sequencer branch shows up as `ok` where `fail` was expected (or the reverse), as stray clock edges during stalls or failed loads, or as a trailing-pulse count other than twelve. All of these appear within one load.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_SETTLE,
        ST_WAIT_REL,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_DONE_CHK,
        ST_TRAIL_HI,
        ST_TRAIL_LO,
        ST_PASS,
        ST_FAIL
    } ld_state_t;

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
    parameter int             WIDTH   = 2,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = value;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int CLK_HZ      = 250_000_000,
    parameter int CCLK_MAX_HZ = 50_000_000,
    parameter int RST_US      = 2,
    parameter int SETTLE_US   = 2,
    parameter int TIMEOUT_US  = 100_000,
    parameter int TRAIL_CLKS  = 12,
    parameter int LEN_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] byte_count,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             abort,
    output logic             cfg_rst_n,
    output logic             cfg_clk,
    output logic             cfg_dat,
    input  logic             cfg_status_n,
    input  logic             cfg_done,
    output logic             busy,
    output logic             ok,
    output logic             fail
);

    localparam longint CYC_US     = longint'(CLK_HZ) / 1_000_000;
    localparam longint RST_CYC    = CYC_US * RST_US;
    localparam longint SETTLE_CYC = CYC_US * SETTLE_US;
    localparam longint TO_CYC     = CYC_US * TIMEOUT_US;
    localparam longint HALF_RAW   = (longint'(CLK_HZ) + 2 * longint'(CCLK_MAX_HZ) - 1)
                                    / (2 * longint'(CCLK_MAX_HZ));
    localparam longint HALF_CYC   = (HALF_RAW < 3) ? 3 : HALF_RAW;
    localparam longint MAX_A      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam longint MAX_B      = (TO_CYC > HALF_CYC) ? TO_CYC : HALF_CYC;
    localparam longint MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int     TMR_W      = $clog2(MAX_CYC + 1);
    localparam int     TR_W       = $clog2(TRAIL_CLKS + 1);

    localparam logic [TMR_W-1:0] RST_LD    = TMR_W'(RST_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] TO_LD     = TMR_W'(TO_CYC - 1);
    localparam logic [TMR_W-1:0] HALF_LD   = TMR_W'(HALF_CYC - 1);

    typedef struct packed {
        ld_state_t         st;
        logic [LEN_W-1:0]  rem;
        logic [BYTE_W-1:0] sh;
        logic [BIT_W-1:0]  bitn;
        logic [TR_W-1:0]   tr;
        logic              rst_n;
        logic              clk;
        logic              ok;
        logic              fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_ld;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             stat_n_s;
    logic             done_s;
    logic             active;

    ps_cfg_sync #(
        .WIDTH   (2),
        .STAGES  (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cfg_done, cfg_status_n}),
        .dout  ({done_s, stat_n_s})
    );

    ps_cfg_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_ld),
        .value (tmr_val),
        .zero  (tmr_zero)
    );

    function automatic ctl_t to_fail(input ctl_t c);
        ctl_t r;
        r       = c;
        r.st    = ST_FAIL;
        r.rst_n = 1'b1;
        r.clk   = 1'b0;
        r.sh    = '0;
        r.ok    = 1'b0;
        r.fail  = 1'b1;
        return r;
    endfunction

    assign active = !(ctl_q.st == ST_IDLE || ctl_q.st == ST_PASS || ctl_q.st == ST_FAIL);

    always_comb begin
        ctl_d   = ctl_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (ctl_q.st)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start) begin
                    ctl_d.st    = ST_RST;
                    ctl_d.rst_n = 1'b0;
                    ctl_d.clk   = 1'b0;
                    ctl_d.sh    = '0;
                    ctl_d.ok    = 1'b0;
                    ctl_d.fail  = 1'b0;
                    ctl_d.rem   = byte_count;
                    ctl_d.tr    = '0;
                    tmr_ld      = 1'b1;
                    tmr_val     = RST_LD;
                end
            end
            ST_RST: begin
                if (tmr_zero) begin
                    if (!stat_n_s) begin
                        ctl_d.st    = ST_SETTLE;
                        ctl_d.rst_n = 1'b1;
                        tmr_ld      = 1'b1;
                        tmr_val     = SETTLE_LD;
                    end else begin
                        ctl_d = to_fail(ctl_q);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_WAIT_REL;
                    tmr_ld   = 1'b1;
                    tmr_val  = TO_LD;
                end
            end
            ST_WAIT_REL: begin
                if (stat_n_s) begin
                    if (ctl_q.rem == '0) begin
                        ctl_d.st = ST_DONE_CHK;
                        tmr_ld   = 1'b1;
                        tmr_val  = HALF_LD;
                    end else begin
                        ctl_d.st = ST_FETCH;
                    end
                end else if (tmr_zero) begin
                    ctl_d = to_fail(ctl_q);
                end
            end
            ST_FETCH: begin
                if (in_valid) begin
                    ctl_d.st   = ST_BIT_LO;
                    ctl_d.sh   = in_data;
                    ctl_d.rem  = ctl_q.rem - 1'b1;
                    ctl_d.bitn = '0;
                    tmr_ld     = 1'b1;
                    tmr_val    = HALF_LD;
                end
            end
            ST_BIT_LO: begin
                if (tmr_zero) begin
                    ctl_d.st  = ST_BIT_HI;
                    ctl_d.clk = 1'b1;
                    tmr_ld    = 1'b1;
                    tmr_val   = HALF_LD;
                end
            end
            ST_BIT_HI: begin
                if (tmr_zero) begin
                    ctl_d.clk = 1'b0;
                    ctl_d.sh  = {1'b0, ctl_q.sh[BYTE_W-1:1]};
                    if (ctl_q.bitn == BIT_W'(BYTE_W - 1)) begin
                        if (ctl_q.rem == '0) begin
                            ctl_d.st = ST_DONE_CHK;
                            tmr_ld   = 1'b1;
                            tmr_val  = HALF_LD;
                        end else begin
                            ctl_d.st = ST_FETCH;
                        end
                    end else begin
                        ctl_d.st   = ST_BIT_LO;
                        ctl_d.bitn = ctl_q.bitn + 1'b1;
                        tmr_ld     = 1'b1;
                        tmr_val    = HALF_LD;
                    end
                end
            end
            ST_DONE_CHK: begin
                if (tmr_zero) begin
                    if (done_s) begin
                        ctl_d.st  = ST_TRAIL_HI;
                        ctl_d.clk = 1'b1;
                        ctl_d.tr  = '0;
                        tmr_ld    = 1'b1;
                        tmr_val   = HALF_LD;
                    end else begin
                        ctl_d = to_fail(ctl_q);
                    end
                end
            end
            ST_TRAIL_HI: begin
                if (tmr_zero) begin
                    ctl_d.st  = ST_TRAIL_LO;
                    ctl_d.clk = 1'b0;
                    tmr_ld    = 1'b1;
                    tmr_val   = HALF_LD;
                end
            end
            ST_TRAIL_LO: begin
                if (tmr_zero) begin
                    if (ctl_q.tr == TR_W'(TRAIL_CLKS - 1)) begin
                        ctl_d.st = ST_PASS;
                        ctl_d.ok = 1'b1;
                    end else begin
                        ctl_d.st  = ST_TRAIL_HI;
                        ctl_d.clk = 1'b1;
                        ctl_d.tr  = ctl_q.tr + 1'b1;
                        tmr_ld    = 1'b1;
                        tmr_val   = HALF_LD;
                    end
                end
            end
            default: begin
                ctl_d = to_fail(ctl_q);
            end
        endcase
        if (active && abort) begin
            ctl_d  = to_fail(ctl_q);
            tmr_ld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.rst_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready  = (ctl_q.st == ST_FETCH);
    assign cfg_rst_n = ctl_q.rst_n;
    assign cfg_clk   = ctl_q.clk;
    assign cfg_dat   = ctl_q.sh[0];
    assign busy      = active;
    assign ok        = ctl_q.ok;
    assign fail      = ctl_q.fail;

endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic busy,
    input logic ok,
    input logic fail,
    input logic in_ready,
    input logic cfg_rst_n,
    input logic cfg_clk,
    input logic cfg_dat
);

    AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && fail)); // R11

    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!cfg_clk && !cfg_dat)); // R7

    AST_ABORT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (fail && !busy)); // R10

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cfg_rst_n && !cfg_clk && !cfg_dat)); // R3

    AST_DATA_HELD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> $stable(cfg_dat)); // R5

    AST_NO_CLK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n |-> !cfg_clk); // R2

    AST_CLK_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_clk) && !abort) |=> cfg_clk); // R6

    AST_CLK_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk) |=> !cfg_clk); // R6

endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .busy      (busy),
    .ok        (ok),
    .fail      (fail),
    .in_ready  (in_ready),
    .cfg_rst_n (cfg_rst_n),
    .cfg_clk   (cfg_clk),
    .cfg_dat   (cfg_dat)
);

// File: tb/ps_cfg_loader_tb.sv
`timescale 1ns/1ps
module ps_cfg_loader_tb;

    localparam int LEN_W = 24;
    localparam int TO_US = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] byte_count = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             abort = 1'b0;
    logic             cfg_rst_n, cfg_clk, cfg_dat;
    logic             cfg_status_n = 1'b1;
    logic             cfg_done;
    logic             busy, ok, fail;

    always #2 clk = ~clk;

    ps_cfg_loader #(.TIMEOUT_US(TO_US), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .abort(abort),
        .cfg_rst_n(cfg_rst_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
        .cfg_status_n(cfg_status_n), .cfg_done(cfg_done),
        .busy(busy), .ok(ok), .fail(fail)
    );

    int total = 0;
    int bad   = 0;

    // target model and link monitor
    int         stat_mode = 0;   // 0 normal, 1 never acknowledges reset, 2 never releases
    int         done_mode = 1;   // 1 raises done after all bits, 0 never
    int         exp_bits  = 0;
    int         rx_bits   = 0;
    logic [7:0] rx_sh     = '0;
    logic [7:0] rx [0:15];
    logic [7:0] tx [0:15];
    logic       tgt_done  = 1'b0;
    int         rel_cnt   = 0;
    int         trail_seen = 0;
    int         rise_cnt  = 0;
    int         setup_bad = 0;
    int         hs_cnt    = 0;
    int         min_w     = 1000000;
    int         w         = 0;
    logic       prev_clk  = 1'b0;
    logic       prev_dat  = 1'b0;

    assign cfg_done = tgt_done;

    always begin
        @(negedge clk);
        #1;
        if (in_ready && in_valid) hs_cnt++;
        if (cfg_clk != prev_clk) begin
            if (w < min_w) min_w = w;
            w = 1;
        end else begin
            w++;
        end
        if (!cfg_rst_n) begin
            cfg_status_n = (stat_mode == 1);
            rel_cnt      = 0;
            rx_bits      = 0;
            tgt_done     = 1'b0;
            trail_seen   = 0;
        end else begin
            if (!cfg_status_n) begin
                rel_cnt++;
                if (rel_cnt >= 50 && stat_mode != 2) cfg_status_n = 1'b1;
            end
            if (cfg_clk && !prev_clk) begin
                rise_cnt++;
                if (cfg_dat != prev_dat) setup_bad++;
                if (tgt_done) begin
                    trail_seen++;
                end else if (cfg_status_n) begin
                    rx_sh = {cfg_dat, rx_sh[7:1]};
                    rx_bits++;
                    if (rx_bits % 8 == 0 && rx_bits <= 128) rx[rx_bits/8-1] = rx_sh;
                    if (rx_bits == exp_bits && done_mode == 1) tgt_done = 1'b1;
                end
            end
        end
        prev_clk = cfg_clk;
        prev_dat = cfg_dat;
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon(input int nbytes);
        exp_bits  = nbytes * 8;
        rise_cnt  = 0;
        setup_bad = 0;
        hs_cnt    = 0;
        min_w     = 1000000;
        for (int i = 0; i < 16; i++) rx[i] = 8'h00;
    endtask

    task automatic kick(input int nbytes);
        @(negedge clk);
        byte_count = LEN_W'(nbytes);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_rst_n == 1'b1, "R1", "cfg_rst_n", cfg_rst_n, 1);
        chk(cfg_clk == 1'b0 && cfg_dat == 1'b0, "R1", "clk|dat", {cfg_clk, cfg_dat}, 0);
        chk({busy, ok, fail, in_ready} == 4'b0, "R1", "busy/ok/fail/ready", {busy, ok, fail, in_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_load(input int n, input int gap_at, input int gap_len, input string tag);
        int rl;
        int r0;
        stat_mode = 0;
        done_mode = 1;
        clear_mon(n);
        kick(n);
        rl = 0;
        while (!cfg_rst_n && rl < 2000) begin
            rl++;
            @(negedge clk);
        end
        chk(rl >= 500 && rl <= 505, "R2", "reset low cycles", rl, 500);
        chk(rise_cnt == 0, "R2", "edges during reset", rise_cnt, 0);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) begin
                while (!in_ready) @(negedge clk);
                r0 = rise_cnt;
                repeat (gap_len) @(negedge clk);
                chk(rise_cnt == r0 && !cfg_clk, "R7", "edges while stalled", rise_cnt - r0, 0);
                chk(in_ready == 1'b1, "R7", "ready while stalled", in_ready, 1);
            end
            send_byte(tx[i]);
        end
        wait_idle();
        repeat (2) @(negedge clk);
        chk(ok && !fail, {"R9 ", tag}, "ok/fail", {ok, fail}, 2);
        chk(trail_seen == 12, "R9", "trailing pulses", trail_seen, 12);
        chk(hs_cnt == n, "R7", "bytes accepted", hs_cnt, n);
        chk(setup_bad == 0, "R5", "data moved at rising edge", setup_bad, 0);
        chk(min_w >= 3, "R6", "min clock phase", min_w, 3);
        chk(rise_cnt == n * 8 + 12, "R5", "total rising edges", rise_cnt, n * 8 + 12);
        for (int i = 0; i < n; i++) begin
            chk(rx[i] == tx[i], {"R5 ", tag}, "byte at target", rx[i], tx[i]);
        end
    endtask

    task automatic t_hold_and_clear();
        repeat (30) @(negedge clk);
        chk(ok && !fail && !busy, "R11", "ok held after pass", {ok, fail, busy}, 4);
        stat_mode = 1;
        clear_mon(1);
        kick(1);
        chk(!ok && !fail && busy, "R11", "start clears ok", {ok, fail, busy}, 1);
    endtask

    task automatic t_no_ack();
        wait_idle();
        @(negedge clk);
        chk(fail && !ok, "R3", "fail without ack", {ok, fail}, 1);
        chk(cfg_rst_n == 1'b1, "R3", "cfg_rst_n released", cfg_rst_n, 1);
        chk(rise_cnt == 0, "R3", "clock edges", rise_cnt, 0);
        stat_mode = 0;
    endtask

    task automatic t_timeout();
        int t;
        stat_mode = 2;
        clear_mon(2);
        kick(2);
        while (!cfg_rst_n) @(negedge clk);
        t = 0;
        while (!fail && t < 10000) begin
            t++;
            @(negedge clk);
        end
        chk(t >= 5495 && t <= 5505, "R4", "release timeout cycles", t, 5500);
        chk(rise_cnt == 0 && cfg_rst_n, "R4", "edges/rst after timeout", rise_cnt, 0);
        stat_mode = 0;
    endtask

    task automatic t_no_done();
        stat_mode = 0;
        done_mode = 0;
        clear_mon(2);
        kick(2);
        send_byte(8'h5A);
        send_byte(8'hC3);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(fail && !ok, "R8", "fail without done", {ok, fail}, 1);
        chk(rise_cnt == 16, "R8", "no trailing pulses", rise_cnt, 16);
        done_mode = 1;
    endtask

    task automatic t_abort();
        clear_mon(4);
        kick(4);
        send_byte(8'hF0);
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy before abort", busy, 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(fail && !busy && !ok, "R10", "fail/busy/ok after abort", {fail, busy, ok}, 4);
        chk(cfg_rst_n && !cfg_clk && !cfg_dat, "R10", "link lines after abort",
            {cfg_rst_n, cfg_clk, cfg_dat}, 4);
        repeat (20) @(negedge clk);
        chk(fail && !ok, "R11", "fail held", {ok, fail}, 1);
    endtask

    initial begin
        t_reset();
        tx[0] = 8'hA5; tx[1] = 8'h01; tx[2] = 8'h80;
        tx[3] = 8'hFF; tx[4] = 8'h00; tx[5] = 8'h3C;
        t_load(6, -1, 0, "mixed");
        t_hold_and_clear();
        t_no_ack();
        tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'h56;
        t_load(3, 1, 100, "stall");
        t_timeout();
        t_no_done();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule